// File: doc/BRIEF.md
# Key Event Post-Processor with Ghost Rejection

This block sits behind a matrix keypad scanner and turns one snapshot of decoded key slots into a stream of key edge events. Each slot carries a valid flag, a row and a column. The block forms a scan code for every valid slot. It can optionally remove a designated function key from the list and move every other key into a second code page. It drops snapshots that show the three-key ghosting pattern of a passive matrix. It then compares the accepted set of keys with the set it accepted last time.

The events leave one at a time on a valid/ready handshake. Releases for keys that disappeared come first, then a press for every key in the new set. A one-cycle done pulse closes every snapshot, including one that was rejected. A snapshot flagged as empty stands for a drained scanner FIFO. It releases every held key and clears the stored set. Keycode translation is left to the consumer, so the block emits scan codes only.

Top module: `kpp_event_gen`

## Requirements
- R1: The scan code of a slot is row * 8 + column (row in bits 6:3, column in bits 2:0 of the 8-bit event code). Bit 7 of the event code is the function-page bit.
- R2: A slot whose valid flag is low contributes nothing. This holds even when its row and column match the function key.
- R3: With function-map mode on, a valid slot whose code equals fn_code_i is removed from the key list. With the mode off, the same slot is an ordinary key.
- R4: When the function key is removed, the code of every other key in that snapshot is increased by 128.
- R5: The ghost check applies only when ghost_en_i is high and at least 3 keys remain after function-key removal.
- R6: A checked snapshot that has one pair of keys sharing a row and one pair sharing a column produces no events. It leaves the stored set unchanged and still ends with a done pulse.
- R7: Each key of the stored set that is absent from the new set yields a release event (press flag 0). These events come in the slot order of the stored set.
- R8: Every key of the new set yields a press event (press flag 1) in slot order. All presses follow all releases of the same snapshot.
- R9: A snapshot with snap_empty_i high ignores its slots. It releases every stored key and empties the stored set.
- R10: evt_valid_o, evt_code_o and evt_press_o hold steady until evt_ready_i accepts the event. snap_ready_o is low while a snapshot is being processed.
- R11: done_o is a one-cycle pulse after the last event of each snapshot. The stored set is replaced by the new set only for accepted snapshots.
- R12: After reset no event is pending, snap_ready_o is high and the stored set is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| snap_valid_i | input | 1 | Snapshot offered |
| snap_ready_o | output | 1 | Snapshot accepted when high with snap_valid_i |
| snap_empty_i | input | 1 | Snapshot marks a drained scanner FIFO |
| ent_vld_i | input | 8 | Valid flag per slot |
| ent_row_i | input | 32 | Row per slot, 4 bits each, slot 0 lowest |
| ent_col_i | input | 24 | Column per slot, 3 bits each, slot 0 lowest |
| fn_map_en_i | input | 1 | Function-map mode enable |
| fn_code_i | input | 7 | Scan code of the function key |
| ghost_en_i | input | 1 | Ghost rejection enable |
| evt_valid_o | output | 1 | Event valid |
| evt_ready_i | input | 1 | Event accepted by consumer |
| evt_code_o | output | 8 | Event scan code including function-page bit |
| evt_press_o | output | 1 | 1 for press, 0 for release |
| done_o | output | 1 | End-of-snapshot pulse |

## Verification
The bench steers a sequence of snapshots so that each one depends on the stored set left by the one before. It also stalls the consumer on a fixed pattern.

A ghost snapshot is followed by one whose releases only match if the rejected set was never stored. A design that committed rejected sets would release the wrong keys. A function key that shares a row with one key and a column with another must not trigger rejection. A design that counted it before removal would drop a valid two-key snapshot. When the function page is entered, every held plain code must be released, because the page bit makes the codes differ. A design that compared without the page bit would lose those releases. An invalid slot that carries the function key's code must not shift the other codes. The empty flag must release keys regardless of slot contents.

// File: rtl/kpp_pkg.sv
package kpp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REL  = 2'd1,
    ST_PRS  = 2'd2,
    ST_DONE = 2'd3
  } kpp_state_e;
endpackage

// File: rtl/kpp_encode.sv
module kpp_encode #(
  parameter int NUM_ENT = 8,
  parameter int ROW_W   = 4,
  parameter int COL_W   = 3,
  localparam int CODE_W = ROW_W + COL_W,
  localparam int OUT_W  = CODE_W + 1
) (
  input  logic [NUM_ENT-1:0]       ent_vld_i,
  input  logic [NUM_ENT*ROW_W-1:0] ent_row_i,
  input  logic [NUM_ENT*COL_W-1:0] ent_col_i,
  input  logic                     fn_en_i,
  input  logic [CODE_W-1:0]        fn_code_i,
  input  logic                     empty_i,
  output logic [NUM_ENT-1:0]       keep_o,
  output logic [NUM_ENT*OUT_W-1:0] code_o
);
  logic [NUM_ENT-1:0] is_fn;
  logic               fn_hit;

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
    logic [CODE_W-1:0] raw;
    assign raw      = {ent_row_i[i*ROW_W +: ROW_W], ent_col_i[i*COL_W +: COL_W]};
    assign is_fn[i] = ent_vld_i[i] & fn_en_i & (raw == fn_code_i);
    assign keep_o[i] = ent_vld_i[i] & ~is_fn[i] & ~empty_i;
    assign code_o[i*OUT_W +: OUT_W] = {fn_hit, raw};
  end

  assign fn_hit = (|is_fn) & ~empty_i;
endmodule

// File: rtl/kpp_ghost.sv
module kpp_ghost #(
  parameter int NUM_ENT = 8,
  parameter int ROW_W   = 4,
  parameter int COL_W   = 3
) (
  input  logic [NUM_ENT-1:0]       keep_i,
  input  logic [NUM_ENT*ROW_W-1:0] ent_row_i,
  input  logic [NUM_ENT*COL_W-1:0] ent_col_i,
  input  logic                     en_i,
  output logic                     ghost_o
);
  logic        row_hit, col_hit;
  int unsigned cnt;

  always_comb begin
    row_hit = 1'b0;
    col_hit = 1'b0;
    for (int i = 0; i < NUM_ENT; i++) begin
      for (int j = i + 1; j < NUM_ENT; j++) begin
        if (keep_i[i] && keep_i[j]) begin
          if (ent_row_i[i*ROW_W +: ROW_W] == ent_row_i[j*ROW_W +: ROW_W]) row_hit = 1'b1;
          if (ent_col_i[i*COL_W +: COL_W] == ent_col_i[j*COL_W +: COL_W]) col_hit = 1'b1;
        end
      end
    end
    cnt     = $countones(keep_i);
    ghost_o = en_i && (cnt >= 3) && row_hit && col_hit;
  end
endmodule

// File: rtl/kpp_match.sv
module kpp_match #(
  parameter int NUM_ENT = 8,
  parameter int OUT_W   = 8
) (
  input  logic [NUM_ENT-1:0]       old_vld_i,
  input  logic [NUM_ENT*OUT_W-1:0] old_code_i,
  input  logic [NUM_ENT-1:0]       new_vld_i,
  input  logic [NUM_ENT*OUT_W-1:0] new_code_i,
  output logic [NUM_ENT-1:0]       gone_o
);
  for (genvar i = 0; i < NUM_ENT; i++) begin : g_old
    logic found;
    always_comb begin
      found = 1'b0;
      for (int j = 0; j < NUM_ENT; j++)
        if (new_vld_i[j] && (new_code_i[j*OUT_W +: OUT_W] == old_code_i[i*OUT_W +: OUT_W]))
          found = 1'b1;
    end
    assign gone_o[i] = old_vld_i[i] & ~found;
  end
endmodule

// File: rtl/kpp_event_gen.sv
module kpp_event_gen
  import kpp_pkg::*;
#(
  parameter int NUM_ENT = 8,
  parameter int ROW_W   = 4,
  parameter int COL_W   = 3,
  localparam int CODE_W = ROW_W + COL_W,
  localparam int OUT_W  = CODE_W + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     snap_valid_i,
  output logic                     snap_ready_o,
  input  logic                     snap_empty_i,
  input  logic [NUM_ENT-1:0]       ent_vld_i,
  input  logic [NUM_ENT*ROW_W-1:0] ent_row_i,
  input  logic [NUM_ENT*COL_W-1:0] ent_col_i,
  input  logic                     fn_map_en_i,
  input  logic [CODE_W-1:0]        fn_code_i,
  input  logic                     ghost_en_i,
  output logic                     evt_valid_o,
  input  logic                     evt_ready_i,
  output logic [OUT_W-1:0]         evt_code_o,
  output logic                     evt_press_o,
  output logic                     done_o
);
  localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_ENT - 1);

  kpp_state_e              state_q;
  logic [IDX_W-1:0]        idx_q;
  logic [NUM_ENT-1:0]      prev_vld_q, new_vld_q;
  logic [NUM_ENT*OUT_W-1:0] prev_code_q, new_code_q;
  logic                    ghost_q;

  logic [NUM_ENT-1:0]       keep;
  logic [NUM_ENT*OUT_W-1:0] codes;
  logic                     ghost;
  logic [NUM_ENT-1:0]       gone;
  logic                     emit, advance, take;

  kpp_encode #(.NUM_ENT(NUM_ENT), .ROW_W(ROW_W), .COL_W(COL_W)) u_encode (
    .ent_vld_i (ent_vld_i),
    .ent_row_i (ent_row_i),
    .ent_col_i (ent_col_i),
    .fn_en_i   (fn_map_en_i),
    .fn_code_i (fn_code_i),
    .empty_i   (snap_empty_i),
    .keep_o    (keep),
    .code_o    (codes)
  );

  kpp_ghost #(.NUM_ENT(NUM_ENT), .ROW_W(ROW_W), .COL_W(COL_W)) u_ghost (
    .keep_i    (keep),
    .ent_row_i (ent_row_i),
    .ent_col_i (ent_col_i),
    .en_i      (ghost_en_i),
    .ghost_o   (ghost)
  );

  kpp_match #(.NUM_ENT(NUM_ENT), .OUT_W(OUT_W)) u_match (
    .old_vld_i  (prev_vld_q),
    .old_code_i (prev_code_q),
    .new_vld_i  (new_vld_q),
    .new_code_i (new_code_q),
    .gone_o     (gone)
  );

  assign snap_ready_o = (state_q == ST_IDLE);
  assign take         = snap_valid_i & snap_ready_o;
  assign done_o       = (state_q == ST_DONE);
  assign evt_press_o  = (state_q == ST_PRS);

  always_comb begin
    case (state_q)
      ST_REL:  emit = gone[idx_q];
      ST_PRS:  emit = new_vld_q[idx_q];
      default: emit = 1'b0;
    endcase
  end

  assign evt_valid_o = emit;
  assign evt_code_o  = (state_q == ST_REL) ? prev_code_q[idx_q*OUT_W +: OUT_W]
                                           : new_code_q[idx_q*OUT_W +: OUT_W];
  assign advance     = ~emit | evt_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      idx_q       <= '0;
      prev_vld_q  <= '0;
      prev_code_q <= '0;
      new_vld_q   <= '0;
      new_code_q  <= '0;
      ghost_q     <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (take) begin
          new_vld_q  <= keep;
          new_code_q <= codes;
          ghost_q    <= ghost;
          idx_q      <= '0;
          state_q    <= ghost ? ST_DONE : ST_REL;
        end
        ST_REL: if (advance) begin
          idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
          if (idx_q == LAST) state_q <= ST_PRS;
        end
        ST_PRS: if (advance) begin
          idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
          if (idx_q == LAST) state_q <= ST_DONE;
        end
        default: begin
          // commit only accepted snapshots
          if (!ghost_q) begin
            prev_vld_q  <= new_vld_q;
            prev_code_q <= new_code_q;
          end
          state_q <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/kpp_event_gen_chk.sv
module kpp_event_gen_chk #(
  parameter int OUT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             snap_ready_o,
  input logic             evt_valid_o,
  input logic             evt_ready_i,
  input logic [OUT_W-1:0] evt_code_o,
  input logic             evt_press_o,
  input logic             done_o
);
  logic seen_press;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_press <= 1'b0;
    else if (done_o) seen_press <= 1'b0;
    else if (evt_valid_o && evt_ready_i && evt_press_o) seen_press <= 1'b1;
  end

  assert_evt_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o && !evt_ready_i |=> evt_valid_o && $stable(evt_code_o) && $stable(evt_press_o));

  assert_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o |-> !snap_ready_o);

  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !evt_valid_o);

  assert_idle_after_done_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> snap_ready_o);

  assert_rel_before_prs_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o && !evt_press_o |-> !seen_press);
endmodule

bind kpp_event_gen kpp_event_gen_chk #(.OUT_W(OUT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .snap_ready_o (snap_ready_o),
  .evt_valid_o  (evt_valid_o),
  .evt_ready_i  (evt_ready_i),
  .evt_code_o   (evt_code_o),
  .evt_press_o  (evt_press_o),
  .done_o       (done_o)
);

// File: tb/kpp_event_gen_bench.sv
module kpp_event_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        snap_valid = 1'b0, snap_ready, snap_empty = 1'b0;
  logic [7:0]  ent_vld = '0;
  logic [31:0] ent_row = '0;
  logic [23:0] ent_col = '0;
  logic        fn_en = 1'b1, ghost_en = 1'b1;
  logic        evt_valid, evt_ready = 1'b0, evt_press, done;
  logic [7:0]  evt_code;

  int checks = 0, errors = 0;
  int ev_n = 0, done_n = 0, cyc = 0;
  logic [8:0] ev_log [32];

  always #5 clk = ~clk;

  kpp_event_gen u_kpp_event_gen (
    .clk_i (clk), .rst_ni (rst_n),
    .snap_valid_i (snap_valid), .snap_ready_o (snap_ready), .snap_empty_i (snap_empty),
    .ent_vld_i (ent_vld), .ent_row_i (ent_row), .ent_col_i (ent_col),
    .fn_map_en_i (fn_en), .fn_code_i (7'd7), .ghost_en_i (ghost_en),
    .evt_valid_o (evt_valid), .evt_ready_i (evt_ready),
    .evt_code_o (evt_code), .evt_press_o (evt_press), .done_o (done)
  );

  // table: slots, modes, expected events {press, code}, event 0 lowest
  localparam int NV = 8;
  localparam logic [7:0]  T_VLD [NV] = '{8'h03, 8'h03, 8'h07, 8'h07, 8'h25, 8'h07, 8'h07, 8'hFF};
  localparam logic [31:0] T_ROW [NV] = '{32'h43, 32'h54, 32'h211, 32'h321, 32'h600100, 32'h222, 32'h500, 32'h12345678};
  localparam logic [23:0] T_COL [NV] = '{24'h08, 24'h11, 24'h51, 24'hD1, 24'h47, 24'hC8, 24'h1CF, 24'h123456};
  localparam logic        T_EMP [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
  localparam int          T_N   [NV] = '{2, 3, 0, 5, 5, 5, 5, 2};
  localparam logic [53:0] T_EV  [NV] = '{
    {9'h0, 9'h0, 9'h0, 9'h0, 9'h121, 9'h118},                 // R1 R8 fresh presses, R12 empty start
    {9'h0, 9'h0, 9'h12A, 9'h121, 9'h018},                     // R7 then R8
    54'h0,                                                    // R5 R6 ghost dropped
    {9'h0, 9'h11B, 9'h112, 9'h109, 9'h02A, 9'h021},           // R6 R11 prev kept through ghost
    {9'h0, 9'h1B0, 9'h189, 9'h01B, 9'h012, 9'h009},           // R3 R4 function page
    {9'h0, 9'h113, 9'h111, 9'h110, 9'h0B0, 9'h089},           // R5 row share only
    {9'h0, 9'h1AF, 9'h181, 9'h013, 9'h011, 9'h010},           // R5 fn removed before ghost count
    {9'h0, 9'h0, 9'h0, 9'h0, 9'h0AF, 9'h081}                  // R9 empty flag
  };

  initial begin
    int k = 0;
    forever begin
      @(posedge clk); #1;
      k++;
      evt_ready = (k % 4) != 1;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n && evt_valid && evt_ready && ev_n < 32) begin
      ev_log[ev_n] = {evt_press, evt_code};
      ev_n++;
    end
    if (rst_n && done) done_n++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic run_snap(input string tag, input logic [7:0] v, input logic [31:0] r,
                          input logic [23:0] c, input logic fe, input logic ge,
                          input logic em, input int exp_n, input logic [53:0] exp_ev);
    @(posedge clk); #1;
    ev_n = 0; done_n = 0;
    ent_vld = v; ent_row = r; ent_col = c;
    fn_en = fe; ghost_en = ge; snap_empty = em;
    snap_valid = 1'b1;
    for (int w = 0; w < 20; w++) begin
      @(negedge clk);
      if (snap_ready) break;
    end
    @(posedge clk); #1;
    snap_valid = 1'b0;
    for (int w = 0; w < 200; w++) begin
      @(negedge clk);
      if (done_n != 0) break;
    end
    repeat (3) @(negedge clk);
    chk({tag, " R11 done count"}, done_n, 1);
    chk({tag, " R7 R8 event count"}, ev_n, exp_n);
    for (int e = 0; e < exp_n && e < 6; e++)
      chk({tag, " R7 R8 event"}, int'(ev_log[e]), int'(exp_ev[e*9 +: 9]));
  endtask

  initial begin
    for (int w = 0; w < 150000; w++) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog actual hung expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R12 reset evt_valid", int'(evt_valid), 0);
    chk("R12 reset snap_ready", int'(snap_ready), 1);
    chk("R12 reset done", int'(done), 0);

    for (int t = 0; t < NV; t++)
      run_snap($sformatf("vec%0d", t), T_VLD[t], T_ROW[t], T_COL[t], 1'b1, 1'b1,
               T_EMP[t], T_N[t], T_EV[t]);

    // R5 ghost pattern accepted with filter off
    run_snap("R5 ghost off", 8'h07, 32'h211, 24'h51, 1'b1, 1'b0, 1'b0, 3,
             {9'h0, 9'h0, 9'h0, 9'h111, 9'h10A, 9'h109});
    // R8 unchanged set pressed again, no releases
    run_snap("R8 repeat", 8'h07, 32'h211, 24'h51, 1'b1, 1'b0, 1'b0, 3,
             {9'h0, 9'h0, 9'h0, 9'h111, 9'h10A, 9'h109});
    // R3 function key is plain with mode off
    run_snap("R3 fn off", 8'h03, 32'h10, 24'h0F, 1'b0, 1'b1, 1'b0, 4,
             {9'h0, 9'h0, 9'h109, 9'h107, 9'h011, 9'h00A});
    // R2 invalid slots ignored, including one holding the fn code
    run_snap("R2 invalid slots", 8'h08, 32'hAAAA7AA0, 24'hFFF7FF, 1'b1, 1'b1, 1'b0, 3,
             {9'h0, 9'h0, 9'h0, 9'h13B, 9'h009, 9'h007});

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule